// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for four-beat memory bursts. A burst begins when chip enable is high and either of two start strobes is high. The external address is then captured. On each later cycle with the advance input high, only the two low address bits move to the next beat. The upper bits keep the captured value until the next load.

A mode input selects one of two beat orders, and its value is taken at load time. Linear order adds the beat number to the starting low bits, modulo four. Interleaved order XORs the beat number into the starting low bits. Bursting is optional: a new address may be loaded on any cycle. A cycle with advance low holds the address, which gives a wait state.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after its release, `addr_out` and `beat_pos` are zero until the first load or advance.
- R2: When `chip_en` is 1 and `start_a` or `start_b` is 1 at a clock edge, then after that edge `addr_out` equals `addr_in` from that edge and `beat_pos` is 0. Either strobe alone is enough.
- R3: When `chip_en` is 0, both strobes have no effect, and the address stays as it was unless `advance` steps it.
- R4: Each edge with `advance` 1 and no load raises `beat_pos` by one modulo 4. An edge with `advance` 0 and no load leaves `addr_out` and `beat_pos` unchanged (wait state).
- R5: With linear order (`order_sel` 0 at load), the low two bits of `addr_out` equal (start + `beat_pos`) mod 4.
- R6: With interleaved order (`order_sel` 1 at load), the low two bits of `addr_out` equal start XOR `beat_pos`.
- R7: Bits above bit 1 of `addr_out` change only on a load.
- R8: The fourth advance after a load returns `addr_out` to the loaded address (the fifth beat equals the first).
- R9: When a load and `advance` occur on the same edge, the load wins and `beat_pos` becomes 0.
- R10: The order is latched at load. Changing `order_sel` in the middle of a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Qualifies both start strobes |
| start_a | input | 1 | First burst-start strobe |
| start_b | input | 1 | Second burst-start strobe |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order; sampled on load |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_pos | output | 2 | Beat index within the burst |

## Verification
Two functions can fall in the same cycle: a load and an advance. The bench raises a strobe together with `advance` while a burst is part-way through. It then expects the new address with beat zero, not the old burst stepped by one. A behavioural model judges every cycle, and the checker asserts that the beat is zero after such a collision.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LOW_W = 2;

  // Low address bits for a given beat under the selected order.
  function automatic logic [LOW_W-1:0] beat_low(
    input logic [LOW_W-1:0] start,
    input logic [LOW_W-1:0] beat,
    input logic             interleave
  );
    if (interleave) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/burst_start_qual.sv
module burst_start_qual (
  input  logic chip_en,
  input  logic start_a,
  input  logic start_b,
  input  logic advance,
  output logic load_evt,
  output logic step_evt
);
  always_comb begin
    load_evt = chip_en & (start_a | start_b);
    step_evt = advance & ~load_evt;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] base_q,
  output logic              mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= 1'b1;
    end else if (load) begin
      base_q <= addr_in;
      mode_q <= order_sel;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [LOW_W-1:0]  beat_pos
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic              load_evt;
  logic              step_evt;
  logic [ADDR_W-1:0] base_q;
  logic              mode_q;
  logic [LOW_W-1:0]  beat_q;

  burst_start_qual u_qual (
    .chip_en (chip_en),
    .start_a (start_a),
    .start_b (start_b),
    .advance (advance),
    .load_evt(load_evt),
    .step_evt(step_evt)
  );

  burst_beat_ctr #(.BEAT_W(LOW_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .step  (step_evt),
    .beat_q(beat_q)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .addr_in  (addr_in),
    .order_sel(order_sel),
    .base_q   (base_q),
    .mode_q   (mode_q)
  );

  always_comb begin
    addr_out = {base_q[ADDR_W-1 -: HI_W], beat_low(base_q[LOW_W-1:0], beat_q, mode_q)};
    beat_pos = beat_q;
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              advance,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat_pos,
  input logic              load_evt,
  input logic              step_evt,
  input logic              mode_q
);
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_out == $past(addr_in)) && (beat_pos == 2'd0));

  p_step_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_pos == $past(beat_pos) + 2'd1);

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> $stable(addr_out) && $stable(beat_pos));

  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !advance) |=> $stable(addr_out));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_out[ADDR_W-1:2]));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !mode_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && advance) |=> beat_pos == 2'd0);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .chip_en (chip_en),
  .advance (advance),
  .addr_in (addr_in),
  .addr_out(addr_out),
  .beat_pos(beat_pos),
  .load_evt(load_evt),
  .step_evt(step_evt),
  .mode_q  (mode_q)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0, start_a = 1'b0, start_b = 1'b0, advance = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_pos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  bit            m_ilv  = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .start_a(start_a), .start_b(start_b),
    .advance(advance), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .beat_pos(beat_pos)
  );

  function automatic logic [AW-1:0] expected_addr();
    int lo;
    int s;
    s = int'(m_base[1:0]);
    if (m_ilv) lo = s ^ m_beat;
    else       lo = (s + m_beat) % 4;
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic compare(input string tag);
    logic [AW-1:0] ea;
    ea = expected_addr();
    checks++;
    if (addr_out !== ea || beat_pos !== 2'(m_beat)) begin
      errors++;
      $display("FAIL %s: addr %h beat %0d, expected addr %h beat %0d",
               tag, addr_out, beat_pos, ea, m_beat);
    end
  endtask

  task automatic cyc(input logic ce, input logic sa, input logic sb, input logic adv,
                     input logic ord, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    chip_en = ce; start_a = sa; start_b = sb; advance = adv; order_sel = ord; addr_in = a;
    @(posedge clk);
    if (ce && (sa || sb)) begin
      m_base = a; m_beat = 0; m_ilv = ord;
    end else if (adv) begin
      m_beat = (m_beat + 1) % 4;
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    #1 compare("R1 reset held");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after release");

    // all start values in both orders, through the wrap
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        a = {16'(s * 16'h1357 + md * 16'h0A0F + 16'h00C3), 2'(s)};
        cyc(1, (s % 2) == 0, (s % 2) == 1, 0, 1'(md), a, "R2 load");
        for (int k = 0; k < 4; k++)
          cyc(1'(k % 2), 0, 0, 1, 1'(!md), '1, md ? "R6 R10 interleaved step" : "R5 R10 linear step");
        checks++;
        if (addr_out !== a) begin
          errors++;
          $display("FAIL R8: wrap addr %h, expected %h", addr_out, a);
        end
        cyc(0, 0, 0, 1, 1'(md), '0, "R7 R8 after wrap");
      end
    end

    // wait states
    cyc(1, 1, 0, 0, 0, 18'h2B5A6, "R2 load for wait test");
    cyc(1, 0, 0, 1, 0, '0, "R4 step");
    cyc(1, 0, 0, 0, 0, 18'h3FFFF, "R4 wait hold");
    cyc(0, 0, 0, 0, 1, 18'h11111, "R4 wait hold 2");
    cyc(1, 0, 0, 1, 1, '0, "R4 step after wait");

    // strobes ignored without chip enable
    cyc(0, 1, 1, 0, 1, 18'h0F0F0, "R3 strobes ignored");
    cyc(0, 1, 0, 1, 1, 18'h0F0F0, "R3 strobe ignored with advance");

    // collision of load and advance
    cyc(1, 0, 1, 1, 1, 18'h15553, "R9 load beats advance");
    cyc(1, 0, 0, 1, 1, '0, "R6 step after collision");
    cyc(1, 1, 0, 1, 0, 18'h2AAA2, "R9 load mid-burst with advance");
    cyc(1, 0, 0, 1, 1, '0, "R5 R10 order held");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule